// File: doc/BRIEF.md
# Two-Source Rising-Edge Interrupt Controller

This block produces a single host interrupt request from two external event pins. Each pin belongs to one parallel-port group and is the only line in that group that can raise an interrupt. Both pins are asynchronous to the block clock. They pass through a synchronizer, are checked for rising edges, and any edge seen while interrupts are enabled sets one shared pending flag. The request output is high while interrupts are enabled and the flag is set.

Software controls the block with plain host read and write strobes that carry a 4-bit offset inside the device's 16-byte window. No data bus is needed. Any write to the control offset turns interrupt generation on. Any read of that same offset turns it off, and the value returned is meaningless. A write to a separate acknowledge offset drops the pending flag once the handler has finished. After reset, generation is off until software turns it on.

Top module: `pio_edge_irq`

## Requirements
- R1: After reset `irq_req` is 0 and generation is off. A rising edge on either pin before the first enable write never raises `irq_req`.
- R2: With generation on, a 0-to-1 change on `evt_pin[0]` sets `irq_req` at the third rising clock edge after the change: two synchronizer stages, then the pending flag.
- R3: With generation on, a 0-to-1 change on `evt_pin[1]` raises `irq_req` with the same three-edge latency.
- R4: Only rising edges count. A falling edge, or a pin that stays high, never sets the pending flag.
- R5: Any write strobe with `host_addr` = 4'hB turns generation on from the next cycle. A synchronized edge in the same cycle as that write is not latched.
- R6: Any read strobe with `host_addr` = 4'hB turns generation off and discards the pending flag. `irq_req` is 0 in the following cycle, even if an edge coincides with the read.
- R7: A write strobe with `host_addr` = 4'hF clears the pending flag, so `irq_req` is 0 in the following cycle.
- R8: Edges that occur while generation is off are not remembered. Enabling later leaves `irq_req` at 0.
- R9: If a synchronized edge is seen in the same cycle as the clear write at 4'hF, the pending flag stays set and `irq_req` stays 1.
- R10: A read at 4'hF, and a read or write at any offset other than 4'hB and 4'hF, leave `irq_req` and the enable state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Offset of the host access within the 16-byte window |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| evt_pin | input | 2 | Asynchronous event pins; bit 0 is group 0, bit 1 is group 1 |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
The bench aims at collisions in a single cycle. These are an edge arriving with the clear write, with the disable read, and with the enable write. A design that ordered clear over set would lose the event. One that let the edge win over disable would leave a stale request pending, and one that read the next enable state would latch an edge that happened before enabling. Edges that arrive while generation is off are followed by a later enable: a design that kept them would fire straight away. Falling edges and pins held high are also driven, to catch detection by level. Strobes at the clear offset with the wrong direction, and at unrelated offsets, are driven to catch decoders that ignore the offset or the direction.

// File: rtl/pio_edge_irq_pkg.sv
// Package: shared types and constants for the two-source edge interrupt block.
// Assumes a 4-bit offset inside a 16-byte device window.
package pio_edge_irq_pkg;

    // Control decoded from one host access
    typedef struct packed {
        logic gen_on;    // enable interrupt generation
        logic gen_off;   // disable generation and drop pending
        logic ack;       // clear pending
    } host_ctl_t;

    localparam int unsigned DEF_ADDR_W   = 4;
    localparam int unsigned DEF_NUM_SRC  = 2;
    localparam int unsigned DEF_SYNC_LEN = 2;

endpackage

// File: rtl/pio_irq_sync.sv
// Module: per-source synchronizer chain.
// Takes NUM_SRC asynchronous pins to the clock domain through SYNC_LEN flops.
// Assumes SYNC_LEN >= 1. Every stage is reset to 0.
module pio_irq_sync #(
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pin_async,
    output logic [NUM_SRC-1:0] pin_sync
);

    localparam int unsigned LAST = SYNC_LEN - 1;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [SYNC_LEN-1:0] chain;

        // Shift the pin through the synchronizer stages
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[SYNC_LEN-1:0], pin_async[s]} >> 0;
            end
        end

        assign pin_sync[s] = chain[LAST];
    end

endmodule

// File: rtl/pio_irq_rise.sv
// Module: rising-edge detector on synchronized source lines.
// A flag is high for one cycle when a line reads 1 and read 0 one cycle earlier.
// Assumes the inputs are already synchronous to clk.
module pio_irq_rise #(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl,
    output logic [NUM_SRC-1:0] rise,
    output logic               rise_any
);

    logic [NUM_SRC-1:0] lvl_d;

    // Remember the previous level of every line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= '0;
        end else begin
            lvl_d <= lvl;
        end
    end

    // Per-line edge flags and their combination
    always_comb begin
        rise     = lvl & ~lvl_d;
        rise_any = |rise;
    end

endmodule

// File: rtl/pio_irq_decode.sv
// Module: host access decoder.
// A write at ON_OFS enables, a read at ON_OFS disables, a write at ACK_OFS acknowledges.
// Assumes one-cycle strobes. All other accesses decode to nothing.
module pio_irq_decode
    import pio_edge_irq_pkg::*;
#(
    parameter int unsigned          ADDR_W  = 4,
    parameter logic [ADDR_W-1:0]    ON_OFS  = 4'hB,
    parameter logic [ADDR_W-1:0]    ACK_OFS = 4'hF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output host_ctl_t         ctl
);

    // Compare the offset once per target and qualify with the strobe direction
    always_comb begin
        ctl.gen_on  = wr && (addr == ON_OFS);
        ctl.gen_off = rd && (addr == ON_OFS);
        ctl.ack     = wr && (addr == ACK_OFS);
    end

endmodule

// File: rtl/pio_irq_state.sv
// Module: enable and pending state.
// Disable has priority over enable. A new edge has priority over acknowledge, so
// an event is not lost. Disable discards pending, so pending implies enabled.
// Assumes edges are one-cycle pulses.
module pio_irq_state
    import pio_edge_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_ctl_t ctl,
    input  logic      edge_seen,
    output logic      en_q,
    output logic      pend_q
);

    // Enable flag: off at reset, disable read wins over enable write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (ctl.gen_off) begin
            en_q <= 1'b0;
        end else if (ctl.gen_on) begin
            en_q <= 1'b1;
        end
    end

    // Pending flag: set by an edge only while enabled, cleared by ack or disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ctl.gen_off) begin
            pend_q <= 1'b0;
        end else if (edge_seen && en_q) begin
            pend_q <= 1'b1;
        end else if (ctl.ack) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pio_edge_irq.sv
// Module: top of the two-source rising-edge interrupt block.
// Chain: synchronizer, edge detector, state. The host decoder drives the state.
// Assumes asynchronous pins and one-cycle host strobes.
module pio_edge_irq
    import pio_edge_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = DEF_ADDR_W,
    parameter int unsigned       NUM_SRC  = DEF_NUM_SRC,
    parameter int unsigned       SYNC_LEN = DEF_SYNC_LEN,
    parameter logic [ADDR_W-1:0] ON_OFS   = 4'hB,
    parameter logic [ADDR_W-1:0] ACK_OFS  = 4'hF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [NUM_SRC-1:0] evt_pin,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] pin_s;
    logic [NUM_SRC-1:0] rise;
    logic               rise_any;
    host_ctl_t          ctl;
    logic               en_q;
    logic               pend_q;

    pio_irq_sync #(.NUM_SRC(NUM_SRC), .SYNC_LEN(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (evt_pin),
        .pin_sync  (pin_s)
    );

    pio_irq_rise #(.NUM_SRC(NUM_SRC)) u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_s),
        .rise     (rise),
        .rise_any (rise_any)
    );

    pio_irq_decode #(.ADDR_W(ADDR_W), .ON_OFS(ON_OFS), .ACK_OFS(ACK_OFS)) u_dec (
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .ctl  (ctl)
    );

    pio_irq_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .edge_seen (rise_any),
        .en_q      (en_q),
        .pend_q    (pend_q)
    );

    // Request is the product of two flops, so it does not glitch
    always_comb irq_req = en_q && pend_q;

endmodule

// File: rtl/pio_edge_irq_chk.sv
// Module: assertion checker bound to pio_edge_irq.
// It watches the host strobes, the edge pulse, the enable flag and the request output.
module pio_edge_irq_chk #(
    parameter int unsigned       ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] ON_OFS  = 4'hB,
    parameter logic [ADDR_W-1:0] ACK_OFS = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic              rise_any,
    input logic              en_q,
    input logic              irq_req
);

    logic hit_on, hit_ack, off_acc;

    // Decoded events, seen from the checker's side
    always_comb begin
        hit_on  = (host_addr == ON_OFS);
        hit_ack = (host_addr == ACK_OFS);
        off_acc = host_rd && hit_on;
    end

    // R5: an enable write without a disable read turns generation on
    p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit_on && !host_rd) |=> en_q);

    // R6: a disable read lowers the request in the next cycle
    p_disable_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_acc |=> (!irq_req && !en_q));

    // R7: a clear write with no concurrent edge lowers the request
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit_ack && !rise_any) |=> !irq_req);

    // R9: an edge with a clear write, while enabled, keeps the request high
    p_edge_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit_ack && rise_any && en_q && !off_acc) |=> irq_req);

    // R2: an edge seen while enabled and not being disabled raises the request
    p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_any && en_q && !off_acc) |=> irq_req);

    // R8: while disabled the request cannot rise in the next cycle
    p_no_latch_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !irq_req) |=> !irq_req);

    // R10: without an edge or a decoded access the request holds its value
    p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_any && !((host_rd || host_wr) && hit_on) && !(host_wr && hit_ack))
        |=> $stable(irq_req));

endmodule

bind pio_edge_irq pio_edge_irq_chk #(
    .ADDR_W (ADDR_W),
    .ON_OFS (ON_OFS),
    .ACK_OFS(ACK_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .rise_any  (rise_any),
    .en_q      (en_q),
    .irq_req   (irq_req)
);

// File: tb/pio_edge_irq_test.sv
// Bench: a vector table walked one cycle per entry, then directed reset tests.
// Entry layout: {req[3:0], op[1:0] (0 none,1 read,2 write), addr[3:0], pins[1:0], exp_irq}.
// Inputs are driven at the falling edge. The output is sampled at the next falling edge.
module pio_edge_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] evt_pin = '0;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pio_edge_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .evt_pin   (evt_pin),
        .irq_req   (irq_req)
    );

    localparam int NV = 49;
    // Tags: R1 reset quiet, R2 src0, R3 src1, R4 no falling, R5 enable,
    // R6 disable, R7 clear, R8 off-edges lost, R9 edge vs clear, R10 other offsets
    localparam logic [12:0] VEC [NV] = '{
        {4'd1, 2'd0, 4'h0, 2'b00, 1'b0},  // 0  R1 idle after reset
        {4'd1, 2'd0, 4'h0, 2'b01, 1'b0},  // 1  R1 src0 rises while off
        {4'd1, 2'd0, 4'h0, 2'b01, 1'b0},  // 2
        {4'd1, 2'd0, 4'h0, 2'b01, 1'b0},  // 3  R1 still low
        {4'd5, 2'd2, 4'hB, 2'b01, 1'b0},  // 4  R5 enable
        {4'd4, 2'd0, 4'h0, 2'b01, 1'b0},  // 5  R4 held high
        {4'd4, 2'd0, 4'h0, 2'b00, 1'b0},  // 6  R4 falling
        {4'd4, 2'd0, 4'h0, 2'b00, 1'b0},  // 7
        {4'd4, 2'd0, 4'h0, 2'b00, 1'b0},  // 8  R4 no trigger
        {4'd2, 2'd0, 4'h0, 2'b01, 1'b0},  // 9  R2 src0 rises
        {4'd2, 2'd0, 4'h0, 2'b01, 1'b0},  // 10
        {4'd2, 2'd0, 4'h0, 2'b01, 1'b1},  // 11 R2 request high
        {4'd7, 2'd2, 4'hF, 2'b01, 1'b0},  // 12 R7 clear
        {4'd7, 2'd0, 4'h0, 2'b00, 1'b0},  // 13
        {4'd7, 2'd0, 4'h0, 2'b00, 1'b0},  // 14
        {4'd3, 2'd0, 4'h0, 2'b10, 1'b0},  // 15 R3 src1 rises
        {4'd3, 2'd0, 4'h0, 2'b10, 1'b0},  // 16
        {4'd3, 2'd0, 4'h0, 2'b10, 1'b1},  // 17 R3 request high
        {4'd10, 2'd1, 4'hF, 2'b10, 1'b1}, // 18 R10 read of clear offset
        {4'd10, 2'd2, 4'h5, 2'b10, 1'b1}, // 19 R10 unrelated write
        {4'd10, 2'd1, 4'h3, 2'b10, 1'b1}, // 20 R10 unrelated read
        {4'd6, 2'd1, 4'hB, 2'b10, 1'b0},  // 21 R6 disable
        {4'd6, 2'd2, 4'hB, 2'b10, 1'b0},  // 22 R6 re-enable, pending gone
        {4'd6, 2'd0, 4'h0, 2'b00, 1'b0},  // 23
        {4'd6, 2'd0, 4'h0, 2'b00, 1'b0},  // 24
        {4'd6, 2'd0, 4'h0, 2'b00, 1'b0},  // 25
        {4'd9, 2'd0, 4'h0, 2'b01, 1'b0},  // 26 R9 src0 rises
        {4'd9, 2'd0, 4'h0, 2'b01, 1'b0},  // 27
        {4'd9, 2'd2, 4'hF, 2'b01, 1'b1},  // 28 R9 clear meets edge
        {4'd7, 2'd2, 4'hF, 2'b01, 1'b0},  // 29 R7 second clear
        {4'd8, 2'd1, 4'hB, 2'b00, 1'b0},  // 30 R8 disable
        {4'd8, 2'd0, 4'h0, 2'b00, 1'b0},  // 31
        {4'd8, 2'd0, 4'h0, 2'b10, 1'b0},  // 32 R8 src1 rises while off
        {4'd8, 2'd0, 4'h0, 2'b10, 1'b0},  // 33
        {4'd8, 2'd0, 4'h0, 2'b10, 1'b0},  // 34
        {4'd8, 2'd2, 4'hB, 2'b10, 1'b0},  // 35 R8 enable later
        {4'd8, 2'd0, 4'h0, 2'b10, 1'b0},  // 36 R8 nothing remembered
        {4'd6, 2'd0, 4'h0, 2'b11, 1'b0},  // 37 R6 src0 rises
        {4'd6, 2'd0, 4'h0, 2'b11, 1'b0},  // 38
        {4'd6, 2'd1, 4'hB, 2'b11, 1'b0},  // 39 R6 disable meets edge
        {4'd6, 2'd2, 4'hB, 2'b11, 1'b0},  // 40
        {4'd6, 2'd0, 4'h0, 2'b11, 1'b0},  // 41 R6 no stale request
        {4'd5, 2'd1, 4'hB, 2'b00, 1'b0},  // 42 R5 disable, pins fall
        {4'd5, 2'd0, 4'h0, 2'b00, 1'b0},  // 43
        {4'd5, 2'd0, 4'h0, 2'b00, 1'b0},  // 44
        {4'd5, 2'd0, 4'h0, 2'b01, 1'b0},  // 45 R5 src0 rises
        {4'd5, 2'd0, 4'h0, 2'b01, 1'b0},  // 46
        {4'd5, 2'd2, 4'hB, 2'b01, 1'b0},  // 47 R5 enable meets edge
        {4'd5, 2'd0, 4'h0, 2'b01, 1'b0}   // 48 R5 edge not latched
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq_req actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        check(irq_req, 1'b0, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            host_rd   = (v[8:7] == 2'd1);
            host_wr   = (v[8:7] == 2'd2);
            host_addr = v[6:3];
            evt_pin   = v[2:1];
            @(negedge clk);
            host_rd = 1'b0;
            host_wr = 1'b0;
            check(irq_req, v[0], $sformatf("R%0d step %0d", v[12:9], i));
        end

        // R2 fresh event, then reset drops the request
        evt_pin = 2'b00; idle(3);
        evt_pin = 2'b01; idle(3);
        check(irq_req, 1'b1, "R2 before reset");
        rst_n = 1'b0; idle(1);
        check(irq_req, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        evt_pin = 2'b00; idle(3);
        evt_pin = 2'b11; idle(4);
        check(irq_req, 1'b0, "R1 off after reset");

        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule